// File: doc/BRIEF.md
# Multi-PHY ATM Cell Port

This block sits on the ATM-layer side of an 8-bit cell bus that is shared by up to four PHY devices. It drives a PHY address and decodes it internally, so each PHY gets its own transmit and receive enable strobe, and it samples the cell-available flags of the addressed PHY only. Flow control happens once per cell. When a PHY is selected for a cell, all 53 bytes of that cell move in one burst. The port has no FIFO: a cell stays in the PHY until the port accepts it.

While idle, the port polls the PHYs round-robin, one address per cycle. Receive always wins over transmit. If the polled PHY has a receive cell, a receive burst starts. A transmit burst starts only when the polled PHY has room for a cell and the internal side says a complete cell is ready. Once a burst has started, it runs to its 53rd byte. The burst can only stall, and only on back-pressure from the internal side. After every cell, the address moves on to the next PHY.

Cells reach the internal side through byte streams with valid/ready.

Receive stream rules:
- `rx_tvalid` is high for the whole receive burst.
- A byte moves only in a cycle where `rx_tvalid` and `rx_tready` are both high.
- While `rx_tready` is low, the PHY receive enable is low, so the PHY must hold its current byte.

Transmit stream rules:
- `tx_tready` is high for the whole transmit burst.
- A byte moves only in a cycle where `tx_tvalid` and `tx_tready` are both high.
- While `tx_tvalid` is low, the PHY transmit enable is low.

Top module: `atm_cell_port`

## Requirements
- R1: A synchronous reset returns the port to idle within one clock, drives every enable low, deasserts `rx_tvalid` and `tx_tready`, and sets `phy_addr` to 0. This holds even in the middle of a cell.
- R2: While idle with nothing to serve at the addressed PHY, `phy_addr` advances by one each cycle and wraps from NUM_PHY-1 to 0.
- R3: If the addressed PHY shows receive cell-available while the port is idle, a receive burst starts on the next clock, even when a transmit cell could also start.
- R4: A transmit burst starts only when the addressed PHY shows transmit cell-available and `tx_cell_avail` is high. If either is missing, no transmit enable is asserted.
- R5: At most one enable bit is high across both directions, and that bit is the one at index `phy_addr`.
- R6: A cell is exactly 53 byte transfers. The start-of-cell flag is high with the first byte only. No enable is asserted in the cycle after the last byte.
- R7: During a receive burst, `rx_tdata` carries `phy_rx_data`. When `rx_tready` is low, the receive enable is low, so no byte is lost or duplicated.
- R8: During a transmit burst, `phy_tx_data` carries `tx_tdata`. When `tx_tvalid` is low, the transmit enable is low. The burst is never interrupted, even if receive cells become available meanwhile.
- R9: After the last byte of a cell, the port returns to idle with `phy_addr` advanced to the next PHY.
- R10: Cell-available flags of PHYs that are not addressed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phy_addr | output | ADDR_W | Address of the PHY being polled or served |
| phy_rx_clav | input | NUM_PHY | Per-PHY receive cell-available |
| phy_tx_clav | input | NUM_PHY | Per-PHY transmit cell-space-available |
| phy_rx_enb | output | NUM_PHY | Per-PHY receive enable, active high, one byte per high cycle |
| phy_tx_enb | output | NUM_PHY | Per-PHY transmit enable, active high, one byte per high cycle |
| phy_rx_data | input | DATA_W | Receive byte from the PHYs |
| phy_tx_data | output | DATA_W | Transmit byte to the PHYs |
| phy_tx_soc | output | 1 | Start of cell with the first transmit byte |
| rx_tdata | output | DATA_W | Receive stream byte |
| rx_tsoc | output | 1 | Receive stream first-byte flag |
| rx_tvalid | output | 1 | Receive stream valid, high for the whole burst |
| rx_tready | input | 1 | Receive stream ready from the sink |
| tx_cell_avail | input | 1 | A complete transmit cell is ready internally |
| tx_tdata | input | DATA_W | Transmit stream byte |
| tx_tvalid | input | 1 | Transmit stream valid |
| tx_tready | output | 1 | Transmit stream ready, high for the whole burst |

## Verification
The bench sets both a receive and a transmit flag on one PHY. A design that weighed transmit first, or took it as a tie, would be caught by the direction of the first enable. It throttles `rx_tready` and `tx_tvalid` mid-cell and checks byte order and count. A port that kept its enable up during a stall would drop or repeat a byte and fail the 53-byte count or the start-of-cell check. It also raises every receive flag during a transmit burst, which exposes a pre-empting arbiter. A reset in mid-cell catches a byte counter or address that survives reset. Tests with flags on a PHY not yet addressed, and with a transmit flag but no ready cell, show up a decoder that ORs all flags or ignores the cell-ready input.

// File: rtl/atm_port_pkg.sv
package atm_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2
  } port_state_e;
endpackage

// File: rtl/atm_poll_arb.sv
// Idle-time polling and direction choice; receive is tested first.
module atm_poll_arb
  import atm_port_pkg::*;
#(
  parameter int NUM_PHY = 4,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_clav_sel,
  input  logic              tx_go,
  input  logic              cell_done,
  output port_state_e       state,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_PHY - 1);

  logic [ADDR_W-1:0] addr_nxt;
  assign addr_nxt = (addr == LAST_ADDR) ? '0 : addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      addr  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rx_clav_sel)  state <= ST_RX;
          else if (tx_go)   state <= ST_TX;
          else              addr  <= addr_nxt;
        end
        ST_RX, ST_TX: begin
          if (cell_done) begin
            state <= ST_IDLE;
            addr  <= addr_nxt;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/atm_byte_ctr.sv
// Counts bytes within a cell; flags the first and the last.
module atm_byte_ctr #(
  parameter int CELL_BYTES = 53
) (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  output logic first,
  output logic last
);
  localparam int CW = $clog2(CELL_BYTES);
  localparam logic [CW-1:0] LAST_IDX = CW'(CELL_BYTES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (beat && cnt == LAST_IDX) cnt <= '0;
    else if (beat)               cnt <= cnt + 1'b1;
  end

  assign first = (cnt == '0);
  assign last  = (cnt == LAST_IDX);
endmodule

// File: rtl/atm_enb_decode.sv
// Fans the strobes out to the addressed PHY and picks its flags.
module atm_enb_decode #(
  parameter int NUM_PHY = 4,
  parameter int ADDR_W  = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rx_strobe,
  input  logic               tx_strobe,
  input  logic [NUM_PHY-1:0] rx_clav,
  input  logic [NUM_PHY-1:0] tx_clav,
  output logic [NUM_PHY-1:0] rx_enb,
  output logic [NUM_PHY-1:0] tx_enb,
  output logic               rx_clav_sel,
  output logic               tx_clav_sel
);
  for (genvar i = 0; i < NUM_PHY; i++) begin : g_phy
    assign rx_enb[i] = rx_strobe && (addr == ADDR_W'(i));
    assign tx_enb[i] = tx_strobe && (addr == ADDR_W'(i));
  end

  always_comb begin
    rx_clav_sel = 1'b0;
    tx_clav_sel = 1'b0;
    for (int i = 0; i < NUM_PHY; i++) begin
      if (addr == ADDR_W'(i)) begin
        rx_clav_sel = rx_clav[i];
        tx_clav_sel = tx_clav[i];
      end
    end
  end
endmodule

// File: rtl/atm_cell_port.sv
module atm_cell_port
  import atm_port_pkg::*;
#(
  parameter int NUM_PHY    = 4,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  phy_addr,
  input  logic [NUM_PHY-1:0] phy_rx_clav,
  input  logic [NUM_PHY-1:0] phy_tx_clav,
  output logic [NUM_PHY-1:0] phy_rx_enb,
  output logic [NUM_PHY-1:0] phy_tx_enb,
  input  logic [DATA_W-1:0]  phy_rx_data,
  output logic [DATA_W-1:0]  phy_tx_data,
  output logic               phy_tx_soc,
  output logic [DATA_W-1:0]  rx_tdata,
  output logic               rx_tsoc,
  output logic               rx_tvalid,
  input  logic               rx_tready,
  input  logic               tx_cell_avail,
  input  logic [DATA_W-1:0]  tx_tdata,
  input  logic               tx_tvalid,
  output logic               tx_tready
);
  port_state_e state;
  logic rx_clav_sel, tx_clav_sel;
  logic rx_strobe, tx_strobe, beat, first, last, cell_done;

  assign rx_strobe = (state == ST_RX) && rx_tready;
  assign tx_strobe = (state == ST_TX) && tx_tvalid;
  assign beat      = rx_strobe || tx_strobe;
  assign cell_done = beat && last;

  atm_poll_arb #(.NUM_PHY(NUM_PHY), .ADDR_W(ADDR_W)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .rx_clav_sel (rx_clav_sel),
    .tx_go       (tx_clav_sel && tx_cell_avail),
    .cell_done   (cell_done),
    .state       (state),
    .addr        (phy_addr)
  );

  atm_byte_ctr #(.CELL_BYTES(CELL_BYTES)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .beat  (beat),
    .first (first),
    .last  (last)
  );

  atm_enb_decode #(.NUM_PHY(NUM_PHY), .ADDR_W(ADDR_W)) u_dec (
    .addr        (phy_addr),
    .rx_strobe   (rx_strobe),
    .tx_strobe   (tx_strobe),
    .rx_clav     (phy_rx_clav),
    .tx_clav     (phy_tx_clav),
    .rx_enb      (phy_rx_enb),
    .tx_enb      (phy_tx_enb),
    .rx_clav_sel (rx_clav_sel),
    .tx_clav_sel (tx_clav_sel)
  );

  assign rx_tvalid   = (state == ST_RX);
  assign rx_tdata    = phy_rx_data;
  assign rx_tsoc     = rx_tvalid && first;
  assign tx_tready   = (state == ST_TX);
  assign phy_tx_data = tx_tdata;
  assign phy_tx_soc  = tx_strobe && first;
endmodule

// File: rtl/atm_cell_port_chk.sv
module atm_cell_port_chk
  import atm_port_pkg::*;
#(
  parameter int NUM_PHY = 4,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  phy_addr,
  input logic [NUM_PHY-1:0] phy_rx_clav,
  input logic [NUM_PHY-1:0] phy_tx_clav,
  input logic [NUM_PHY-1:0] phy_rx_enb,
  input logic [NUM_PHY-1:0] phy_tx_enb,
  input logic               tx_cell_avail,
  input logic               rx_tvalid,
  input logic               rx_tready,
  input port_state_e        state
);
  function automatic logic [ADDR_W-1:0] nxt(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(NUM_PHY - 1)) ? '0 : a + 1'b1;
  endfunction

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (state == ST_IDLE && phy_addr == '0)); // R1
  AST_POLL_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !phy_rx_clav[phy_addr] && !(phy_tx_clav[phy_addr] && tx_cell_avail))
    |=> (phy_addr == nxt($past(phy_addr)))); // R2
  AST_RX_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && phy_rx_clav[phy_addr]) |=> (state == ST_RX)); // R3
  AST_TX_GUARD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !(phy_tx_clav[phy_addr] && tx_cell_avail)) |=> (state != ST_TX)); // R4
  AST_ONE_ENB: assert property (@(posedge clk) disable iff (rst)
    $onehot0({phy_rx_enb, phy_tx_enb})); // R5
  AST_ENB_AT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (|{phy_rx_enb, phy_tx_enb}) |-> (phy_rx_enb[phy_addr] || phy_tx_enb[phy_addr])); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_tvalid && !rx_tready) |-> (phy_rx_enb == '0)); // R7
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX) |=> (state != ST_RX)); // R8
endmodule

bind atm_cell_port atm_cell_port_chk #(.NUM_PHY(NUM_PHY), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .phy_addr      (phy_addr),
  .phy_rx_clav   (phy_rx_clav),
  .phy_tx_clav   (phy_tx_clav),
  .phy_rx_enb    (phy_rx_enb),
  .phy_tx_enb    (phy_tx_enb),
  .tx_cell_avail (tx_cell_avail),
  .rx_tvalid     (rx_tvalid),
  .rx_tready     (rx_tready),
  .state         (state)
);

// File: tb/atm_cell_port_tb.sv
`timescale 1ns/100ps
module atm_cell_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] phy_addr;
  logic [3:0] phy_rx_clav = '0, phy_tx_clav = '0;
  logic [3:0] phy_rx_enb, phy_tx_enb;
  logic [7:0] phy_rx_data = '0, phy_tx_data, rx_tdata, tx_tdata = '0;
  logic       phy_tx_soc, rx_tsoc, rx_tvalid, tx_tready;
  logic       rx_tready = 1'b0, tx_cell_avail = 1'b0, tx_tvalid = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  atm_cell_port u_dut (
    .clk(clk), .rst(rst), .phy_addr(phy_addr),
    .phy_rx_clav(phy_rx_clav), .phy_tx_clav(phy_tx_clav),
    .phy_rx_enb(phy_rx_enb), .phy_tx_enb(phy_tx_enb),
    .phy_rx_data(phy_rx_data), .phy_tx_data(phy_tx_data), .phy_tx_soc(phy_tx_soc),
    .rx_tdata(rx_tdata), .rx_tsoc(rx_tsoc), .rx_tvalid(rx_tvalid), .rx_tready(rx_tready),
    .tx_cell_avail(tx_cell_avail), .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid),
    .tx_tready(tx_tready)
  );

  // dir: 0 none, 1 receive, 2 transmit; phy: first PHY served from address 0
  typedef struct packed {
    logic [3:0] rxm;
    logic [3:0] txm;
    logic       av;
    logic [1:0] dir;
    logic [1:0] phy;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, 4'b0000, 1'b0, 2'd1, 2'd0},
    '{4'b0000, 4'b0100, 1'b1, 2'd2, 2'd2},
    '{4'b0100, 4'b0100, 1'b1, 2'd1, 2'd2},
    '{4'b0000, 4'b0010, 1'b0, 2'd0, 2'd0},
    '{4'b1000, 4'b0010, 1'b1, 2'd2, 2'd1},
    '{4'b0000, 4'b1000, 1'b1, 2'd2, 2'd3}
  };

  function automatic logic [7:0] rxb(input int p, input int i);
    return 8'((p << 6) ^ i ^ 8'h35);
  endfunction
  function automatic logic [7:0] txb(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // reset held for two edges, state checked while still in reset; released just after an edge
  task automatic do_reset();
    rst = 1'b1;
    phy_rx_clav = '0; phy_tx_clav = '0; tx_cell_avail = 1'b0;
    rx_tready = 1'b0; tx_tvalid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "enables in reset", int'({phy_rx_enb, phy_tx_enb}), 0);
    check("R1", "addr in reset", int'(phy_addr), 0);
    check("R1", "stream flags in reset", int'({rx_tvalid, tx_tready}), 0);
    @(posedge clk); #0.5;
    rst = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int idx = 0;
    bit found = 1'b0;
    phy_rx_clav = v.rxm; phy_tx_clav = v.txm; tx_cell_avail = v.av;
    for (int cyc = 0; cyc < 600; cyc++) begin
      rx_tready   = (cyc % 5 != 3);
      tx_tvalid   = (cyc % 7 != 4);
      phy_rx_data = rxb(v.phy, idx);
      tx_tdata    = txb(idx);
      if (v.dir == 2'd2 && idx >= 20) phy_rx_clav = 4'hF;
      @(negedge clk);
      if (!found && (|{phy_rx_enb, phy_tx_enb})) begin
        found = 1'b1;
        if (v.dir == 2'd1) check("R3", "first enable is receive", int'(phy_rx_enb), 1 << v.phy);
        else if (v.dir == 2'd2) check("R4", "first enable is transmit", int'(phy_tx_enb), 1 << v.phy);
        else check("R4", "no enable expected", int'({phy_rx_enb, phy_tx_enb}), 0);
      end
      if (v.dir == 2'd0) begin
        check("R2", "poll address", int'(phy_addr), cyc % 4);
        if (cyc == 11) return;
      end else if (found) begin
        check("R5", "addr held in cell", int'(phy_addr), int'(v.phy));
        if (v.dir == 2'd1) begin
          check("R8", "no tx enable in rx cell", int'(phy_tx_enb), 0);
          if (!rx_tready) check("R7", "rx enable low on stall", int'(phy_rx_enb), 0);
          if (phy_rx_enb != 0) begin
            check("R5", "rx enable bit", int'(phy_rx_enb), 1 << v.phy);
            check("R7", "rx byte", int'(rx_tdata), int'(rxb(v.phy, idx)));
            check("R6", "rx soc", int'(rx_tsoc), int'(idx == 0));
            idx++;
          end
        end else begin
          check("R8", "no rx enable in tx cell", int'(phy_rx_enb), 0);
          check("R8", "tx ready in cell", int'(tx_tready), 1);
          if (!tx_tvalid) check("R8", "tx enable low on stall", int'(phy_tx_enb), 0);
          if (phy_tx_enb != 0) begin
            check("R5", "tx enable bit", int'(phy_tx_enb), 1 << v.phy);
            check("R8", "tx byte", int'(phy_tx_data), int'(txb(idx)));
            check("R6", "tx soc", int'(phy_tx_soc), int'(idx == 0));
            idx++;
          end
        end
        if (idx == 53) begin
          @(posedge clk); #0.5;
          @(negedge clk);
          check("R6", "no enable after 53rd byte", int'({phy_rx_enb, phy_tx_enb}), 0);
          check("R9", "addr after cell", int'(phy_addr), (v.phy + 1) % 4);
          return;
        end
      end
      @(posedge clk); #0.5;
    end
    check("R6", "cell did not complete", idx, 53);
  endtask

  initial begin
    for (int n = 0; n < NV; n++) begin
      do_reset();
      run_vec(VECS[n]);
    end

    // R1: reset in the middle of a receive cell
    do_reset();
    phy_rx_clav = 4'b0010; rx_tready = 1'b1;
    for (int k = 0; k < 14; k++) begin @(posedge clk); #0.5; end
    rst = 1'b1;
    @(posedge clk); #0.5;
    @(negedge clk);
    check("R1", "enables after mid-cell reset", int'({phy_rx_enb, phy_tx_enb}), 0);
    check("R1", "addr after mid-cell reset", int'(phy_addr), 0);
    check("R1", "rx_tvalid after mid-cell reset", int'(rx_tvalid), 0);

    // R4: transmit waits for the internal cell, then starts
    do_reset();
    phy_tx_clav = 4'b0001; tx_tvalid = 1'b1; tx_tdata = txb(0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R4", "tx enable without cell", int'(phy_tx_enb), 0);
      @(posedge clk); #0.5;
    end
    tx_cell_avail = 1'b1;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (phy_tx_enb == 4'b0001) seen = 1'b1;
        @(posedge clk); #0.5;
      end
      check("R4", "tx starts once cell ready", int'(seen), 1);
    end

    // R10: flag on PHY 2 is ignored until address 2 is polled
    do_reset();
    phy_rx_clav = 4'b0100; rx_tready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10", "no enable before addr 2", int'({phy_rx_enb, phy_tx_enb}), 0);
      @(posedge clk); #0.5;
    end
    @(negedge clk);
    check("R10", "rx enable on phy 2", int'(phy_rx_enb), 4'b0100);

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule